// File: doc/BRIEF.md
# Banked-File AND Execution Unit

This unit carries out one instruction: the bitwise AND of an internal 8-bit working register with one byte taken from a banked data file. A single control bit in the instruction chooses the destination. The result either replaces the working register or is written back to the file byte it came from. A second bit chooses how the 12-bit file address is formed. In one mode, a fixed split window reaches the low half of bank 0 and the high half of the top bank. In the other mode, an external 4-bit bank number is placed above the 8-bit offset.

The data file is outside the unit. The unit reads it through a read port that it strobes in the second phase, and writes it through a write port that it strobes in the fourth phase. Each accepted instruction runs for four cycles: a decode phase, a file-read phase, a combine phase and a write phase. Only the zero and negative bits of the status register change. The other status bits keep their values. While the unit is idle, an outside sequencer can preload the working register and the status register.

Top module: `rfand_exec`

## Requirements
- R1: With `busy` low, a high `issue` starts an instruction only when `instr[15:10]` equals 6'b000101. Any other opcode leaves `busy` low and leaves all state unchanged.
- R2: An accepted instruction keeps `busy` high for exactly four cycles. `done` is high only in the fourth cycle. `rd_en` is high only in the second cycle.
- R3: With `instr[8]` = 0 the effective address is `{4'h0, f}` when `f` is below 0x80, and `{4'hF, f}` when `f` is 0x80 or above. Here `f` is `instr[7:0]`.
- R4: With `instr[8]` = 1 the effective address is `{bank_sel, f}`.
- R5: With `instr[9]` = 0 the AND result replaces the working register when the instruction ends, and no file write takes place.
- R6: With `instr[9]` = 1 the result is written to the file at the effective address during the fourth cycle, and the working register keeps its value.
- R7: Status bit 2 (zero) is set at the end of the instruction exactly when the 8-bit result is 0x00.
- R8: Status bit 4 (negative) takes bit 7 of the result at the end of the instruction.
- R9: Status bits 0, 1 and 3 are never changed by an instruction.
- R10: An `issue` while `busy` is high is ignored. The running instruction completes unchanged and no second one follows.
- R11: Reset clears the working register and the status register and leaves the unit idle. While idle, `w_load` or `st_load` loads `w_load_val` or `st_load_val` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue | input | 1 | Instruction offered this cycle |
| instr | input | 16 | Instruction word |
| bank_sel | input | 4 | Bank number used when instr[8] = 1 |
| w_load | input | 1 | Preload strobe for the working register (idle only) |
| w_load_val | input | 8 | Preload value for the working register |
| st_load | input | 1 | Preload strobe for the status register (idle only) |
| st_load_val | input | 5 | Preload value for the status register |
| rd_en | output | 1 | File read strobe (second phase) |
| rd_addr | output | 12 | File read address |
| rd_data | input | 8 | File read data, sampled at the end of the read phase |
| wr_en | output | 1 | File write strobe (fourth phase, file destination) |
| wr_addr | output | 12 | File write address |
| wr_data | output | 8 | File write data |
| w_out | output | 8 | Working register |
| status_out | output | 5 | Status: bit0 carry, bit1 digit carry, bit2 zero, bit3 overflow, bit4 negative |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Fourth (write) phase of an instruction |

## Verification
The assertions assume the following about the inputs. The file returns read data within the read phase. `rd_data` is sampled only at the edge that ends that phase. The preload strobes matter only while the unit is idle. The stimulus respects these assumptions: the bench's file model answers every read strobe before the next edge, and both preload strobes are driven only between instructions. `bank_sel` is held steady for the whole of each instruction. The one deliberate breach of the issue protocol is a second `issue` raised in mid-instruction, to show that it is ignored.

// File: rtl/rfand_pkg.sv
// Package: shared phase encoding, opcode pattern and status bit positions
// for the banked-file AND execution unit.
package rfand_pkg;

    // Execution phases. IDLE sits between instructions; Q1..Q4 are the
    // decode, read, combine and write quarters of one instruction.
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_Q1   = 3'd1,
        PH_Q2   = 3'd2,
        PH_Q3   = 3'd3,
        PH_Q4   = 3'd4
    } phase_t;

    // Upper six bits of the instruction word that select this operation.
    localparam logic [5:0] OPC_AND_FILE = 6'b000101;

    // Status register layout.
    localparam int STAT_W = 5;
    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_OV = 3;
    localparam int FLG_N  = 4;

endpackage

// File: rtl/rfand_decode.sv
// Module: rfand_decode
// Splits an instruction word into its fields and forms the effective file
// address. Assumes the opcode lives in the bits above the two mode bits
// and the file offset. Purely combinational.
module rfand_decode #(
    parameter int INSTR_W = 16,
    parameter int FADDR_W = 8,
    parameter int BSR_W   = 4
) (
    input  logic [INSTR_W-1:0]       word,
    input  logic [BSR_W-1:0]         bank_sel,
    output logic                     opc_hit,
    output logic                     dest_file,
    output logic                     use_bank_reg,
    output logic [BSR_W+FADDR_W-1:0] eff_addr
);
    import rfand_pkg::*;

    localparam int OPC_LO = FADDR_W + 2;
    localparam int OPC_W  = INSTR_W - OPC_LO;

    logic [FADDR_W-1:0] offset;
    logic [BSR_W-1:0]   bank;

    // Field extraction.
    always_comb begin
        offset       = word[FADDR_W-1:0];
        use_bank_reg = word[FADDR_W];
        dest_file    = word[FADDR_W+1];
        opc_hit      = (word[INSTR_W-1:OPC_LO] == OPC_AND_FILE[OPC_W-1:0]);
    end

    // Bank choice: the split window copies the offset's top bit into every
    // bank bit, giving bank 0 for the low half and the top bank for the rest.
    always_comb begin
        if (use_bank_reg) bank = bank_sel;
        else              bank = {BSR_W{offset[FADDR_W-1]}};
        eff_addr = {bank, offset};
    end

endmodule

// File: rtl/rfand_seq.sv
// Module: rfand_seq
// Four-quarter phase sequencer. Leaves IDLE on an accept pulse, then steps
// through Q1..Q4 once and returns to IDLE. Assumes the caller raises accept
// only while the phase is IDLE.
module rfand_seq (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    output rfand_pkg::phase_t phase
);
    import rfand_pkg::*;

    phase_t phase_nx;

    // Next-phase selection.
    always_comb begin
        unique case (phase)
            PH_IDLE: phase_nx = accept ? PH_Q1 : PH_IDLE;
            PH_Q1:   phase_nx = PH_Q2;
            PH_Q2:   phase_nx = PH_Q3;
            PH_Q3:   phase_nx = PH_Q4;
            PH_Q4:   phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

endmodule

// File: rtl/rfand_alu.sv
// Module: rfand_alu
// Bitwise AND of two operands, with zero and sign indications for the
// result. Purely combinational.
module rfand_alu #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic [DATA_W-1:0] res,
    output logic              is_zero,
    output logic              is_neg
);

    // Combine operands and derive flags.
    always_comb begin
        res     = opa & opb;
        is_zero = (res == '0);
        is_neg  = res[DATA_W-1];
    end

endmodule

// File: rtl/rfand_exec.sv
// Module: rfand_exec (top)
// Executes the AND of the working register with a banked file byte over four
// quarter phases: Q1 decodes the latched word and fixes the address, Q2
// reads the file, Q3 combines, Q4 writes the file or the working register
// and updates the zero and negative status bits. Assumes the external file
// answers a read within the Q2 cycle and that preloads arrive only while idle.
module rfand_exec #(
    parameter int INSTR_W = 16,
    parameter int DATA_W  = 8,
    parameter int FADDR_W = 8,
    parameter int BSR_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      issue,
    input  logic [INSTR_W-1:0]        instr,
    input  logic [BSR_W-1:0]          bank_sel,
    input  logic                      w_load,
    input  logic [DATA_W-1:0]         w_load_val,
    input  logic                      st_load,
    input  logic [4:0]                st_load_val,
    output logic                      rd_en,
    output logic [BSR_W+FADDR_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0]         rd_data,
    output logic                      wr_en,
    output logic [BSR_W+FADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]         wr_data,
    output logic [DATA_W-1:0]         w_out,
    output logic [4:0]                status_out,
    output logic                      busy,
    output logic                      done
);
    import rfand_pkg::*;

    localparam int EA_W = BSR_W + FADDR_W;

    phase_t              phase;
    logic [INSTR_W-1:0]  ir_q;
    logic [EA_W-1:0]     ea_q;
    logic                dest_q;
    logic [DATA_W-1:0]   opnd_q;
    logic [DATA_W-1:0]   res_q;
    logic                zero_q;
    logic                neg_q;
    logic [DATA_W-1:0]   w_q;
    logic [STAT_W-1:0]   stat_q;

    logic                in_hit;
    logic                in_dest_unused;
    logic                in_bank_unused;
    logic [EA_W-1:0]     in_ea_unused;
    logic                ir_hit_unused;
    logic                ir_dest;
    logic                ir_bank_unused;
    logic [EA_W-1:0]     ir_ea;
    logic [DATA_W-1:0]   alu_res;
    logic                alu_zero;
    logic                alu_neg;
    logic                idle;
    logic                accept;

    // Opcode check on the offered word.
    rfand_decode #(.INSTR_W(INSTR_W), .FADDR_W(FADDR_W), .BSR_W(BSR_W)) u_dec_in (
        .word         (instr),
        .bank_sel     (bank_sel),
        .opc_hit      (in_hit),
        .dest_file    (in_dest_unused),
        .use_bank_reg (in_bank_unused),
        .eff_addr     (in_ea_unused)
    );

    // Field decode of the latched word during Q1.
    rfand_decode #(.INSTR_W(INSTR_W), .FADDR_W(FADDR_W), .BSR_W(BSR_W)) u_dec_ir (
        .word         (ir_q),
        .bank_sel     (bank_sel),
        .opc_hit      (ir_hit_unused),
        .dest_file    (ir_dest),
        .use_bank_reg (ir_bank_unused),
        .eff_addr     (ir_ea)
    );

    rfand_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .phase  (phase)
    );

    rfand_alu #(.DATA_W(DATA_W)) u_alu (
        .opa     (w_q),
        .opb     (opnd_q),
        .res     (alu_res),
        .is_zero (alu_zero),
        .is_neg  (alu_neg)
    );

    // Acceptance only from idle with a matching opcode.
    always_comb begin
        idle   = (phase == PH_IDLE);
        accept = idle && issue && in_hit;
    end

    // Instruction latch on accept.
    always_ff @(posedge clk) begin
        if (!rst_n)      ir_q <= '0;
        else if (accept) ir_q <= instr;
    end

    // Q1: fix the effective address and destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            dest_q <= 1'b0;
        end else if (phase == PH_Q1) begin
            ea_q   <= ir_ea;
            dest_q <= ir_dest;
        end
    end

    // Q2: capture the file operand.
    always_ff @(posedge clk) begin
        if (!rst_n)               opnd_q <= '0;
        else if (phase == PH_Q2)  opnd_q <= rd_data;
    end

    // Q3: capture result and flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q  <= '0;
            zero_q <= 1'b0;
            neg_q  <= 1'b0;
        end else if (phase == PH_Q3) begin
            res_q  <= alu_res;
            zero_q <= alu_zero;
            neg_q  <= alu_neg;
        end
    end

    // Working register: idle preload or Q4 write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)                         w_q <= '0;
        else if (idle && w_load)            w_q <= w_load_val;
        else if (phase == PH_Q4 && !dest_q) w_q <= res_q;
    end

    // Status register: idle preload or Q4 zero/negative update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else if (idle && st_load) begin
            stat_q <= st_load_val;
        end else if (phase == PH_Q4) begin
            stat_q[FLG_Z] <= zero_q;
            stat_q[FLG_N] <= neg_q;
        end
    end

    // Port drive.
    always_comb begin
        busy       = !idle;
        done       = (phase == PH_Q4);
        rd_en      = (phase == PH_Q2);
        rd_addr    = ea_q;
        wr_en      = (phase == PH_Q4) && dest_q;
        wr_addr    = ea_q;
        wr_data    = res_q;
        w_out      = w_q;
        status_out = stat_q;
    end

endmodule

// File: rtl/rfand_exec_chk.sv
// Module: rfand_exec_chk
// Property checker for rfand_exec, attached by bind. Observes ports plus the
// phase register and the latched mode bits.
module rfand_exec_chk #(
    parameter int FADDR_W = 8,
    parameter int BSR_W   = 4,
    parameter int DATA_W  = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input rfand_pkg::phase_t        phase,
    input logic                     dest_bit,
    input logic                     bank_bit,
    input logic                     w_load,
    input logic                     st_load,
    input logic                     rd_en,
    input logic [BSR_W+FADDR_W-1:0] rd_addr,
    input logic                     wr_en,
    input logic                     done,
    input logic                     busy,
    input logic [DATA_W-1:0]        w_out,
    input logic [4:0]               status_out
);
    import rfand_pkg::*;

    logic past_ok;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_q1_step: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_Q1 |=> phase == PH_Q2);
    a_r2_q2_step: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_Q2 |=> phase == PH_Q3);
    a_r2_q3_step: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_Q3 |=> done);
    a_r2_q4_end: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r2_read_in_q2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> phase == PH_Q2);
    a_r6_write_needs_dest: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done && dest_bit);
    a_r3_split_window: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !bank_bit) |->
            rd_addr[BSR_W+FADDR_W-1:FADDR_W] == {BSR_W{rd_addr[FADDR_W-1]}});
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> phase != PH_Q1);
    a_r6_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(!busy && w_load) && !$past(done && !dest_bit))
            |-> $stable(w_out));
    a_r9_other_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(!busy && st_load))
            |-> ($stable(status_out[FLG_C]) && $stable(status_out[FLG_DC])
                 && $stable(status_out[FLG_OV])));

endmodule

bind rfand_exec rfand_exec_chk #(.FADDR_W(FADDR_W), .BSR_W(BSR_W), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .dest_bit   (dest_q),
    .bank_bit   (ir_q[FADDR_W]),
    .w_load     (w_load),
    .st_load    (st_load),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .wr_en      (wr_en),
    .done       (done),
    .busy       (busy),
    .w_out      (w_out),
    .status_out (status_out)
);

// File: tb/test_rfand_exec.sv
`timescale 1ns/1ps
module test_rfand_exec;

    typedef struct {
        logic [11:0] ea;
        logic        wr;
        logic [7:0]  res;
        logic [7:0]  exp_w;
        logic [4:0]  exp_st;
        logic [7:0]  exp_file;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] instr = '0;
    logic [3:0]  bank_sel = '0;
    logic        w_load = 1'b0;
    logic [7:0]  w_load_val = '0;
    logic        st_load = 1'b0;
    logic [4:0]  st_load_val = '0;
    logic        rd_en;
    logic [11:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        wr_en;
    logic [11:0] wr_addr;
    logic [7:0]  wr_data;
    logic [7:0]  w_out;
    logic [4:0]  status_out;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] fmem [int];
    item_t      sb_q [$];
    logic [7:0] w_m = '0;
    logic [4:0] st_m = '0;

    always #4 clk = ~clk;

    rfand_exec i_rfand_exec (
        .clk(clk), .rst_n(rst_n), .issue(issue), .instr(instr),
        .bank_sel(bank_sel), .w_load(w_load), .w_load_val(w_load_val),
        .st_load(st_load), .st_load_val(st_load_val), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .w_out(w_out),
        .status_out(status_out), .busy(busy), .done(done)
    );

    function automatic logic [7:0] mget(input logic [11:0] a);
        if (fmem.exists(int'(a))) return fmem[int'(a)];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // File model: answers reads and takes writes mid-cycle.
    always @(negedge clk) begin
        if (rd_en) rd_data <= mget(rd_addr);
        if (wr_en) fmem[int'(wr_addr)] = wr_data;
    end

    // Monitor: compares the design against the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en && sb_q.size() > 0)
                check("R3/R4 rd_addr", rd_addr, sb_q[0].ea);
            if (done && sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(it.wr ? "R6 wr_en" : "R5 wr_en", wr_en, it.wr);
                if (it.wr) begin
                    check("R6 wr_addr", wr_addr, it.ea);
                    check("R6 wr_data", wr_data, it.res);
                end
                @(negedge clk);
                check("R5/R6 w_out", w_out, it.exp_w);
                check("R7 zero flag", status_out[2], it.exp_st[2]);
                check("R8 negative flag", status_out[4], it.exp_st[4]);
                check("R9 other flags", {status_out[3], status_out[1:0]},
                      {it.exp_st[3], it.exp_st[1:0]});
                check("R5/R6 file byte", mget(it.ea), it.exp_file);
            end
        end
    end

    // Driver: computes the expected outcome, pushes it, then issues.
    task automatic run(input logic d, input logic a, input logic [7:0] f,
                       input logic [3:0] bsr, input bit overlap);
        item_t it;
        logic [7:0] opnd;
        int cyc;
        it.ea    = a ? {bsr, f} : {{4{f[7]}}, f};
        opnd     = mget(it.ea);
        it.res   = w_m & opnd;
        it.wr    = d;
        if (!d) w_m = it.res;
        st_m[2]  = (it.res == 8'h00);
        st_m[4]  = it.res[7];
        it.exp_w = w_m;
        it.exp_st = st_m;
        it.exp_file = d ? it.res : opnd;
        sb_q.push_back(it);
        @(negedge clk);
        bank_sel = bsr;
        instr = {6'b000101, d, a, f};
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        cyc = 0;
        while (busy && cyc < 10) begin
            cyc++;
            if (overlap && cyc == 2) begin
                instr = {6'b000101, 1'b0, 1'b0, 8'h00};
                issue = 1'b1;
            end else begin
                issue = 1'b0;
            end
            @(negedge clk);
        end
        issue = 1'b0;
        check(overlap ? "R10 busy length" : "R2 busy length", cyc, 4);
    endtask

    task automatic load_w(input logic [7:0] v);
        @(negedge clk);
        w_load = 1'b1; w_load_val = v;
        @(negedge clk);
        w_load = 1'b0;
        w_m = v;
        check("R11 w preload", w_out, v);
    endtask

    task automatic load_st(input logic [4:0] v);
        @(negedge clk);
        st_load = 1'b1; st_load_val = v;
        @(negedge clk);
        st_load = 1'b0;
        st_m = v;
        check("R11 status preload", status_out, v);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 reset w", w_out, 8'h00);
        check("R11 reset status", status_out, 5'h00);
        check("R11 reset busy", busy, 1'b0);
        check("R2 reset done", done, 1'b0);

        // Worked case: W=0x17, file=0xC2, result to W.
        fmem[int'(12'h020)] = 8'hC2;
        load_w(8'h17);
        run(1'b0, 1'b0, 8'h20, 4'h0, 0);
        check("R5 worked w", w_out, 8'h02);

        // Bank register, file destination, negative result.
        fmem[int'(12'h344)] = 8'hF0;
        load_w(8'h8F);
        run(1'b1, 1'b1, 8'h44, 4'h3, 0);

        // Split window high half, zero result.
        fmem[int'(12'hF90)] = 8'h0F;
        load_w(8'hF0);
        run(1'b1, 1'b0, 8'h90, 4'h2, 0);
        run(1'b0, 1'b1, 8'h90, 4'hF, 0);

        // Window boundary offsets.
        fmem[int'(12'h07F)] = 8'h5A;
        fmem[int'(12'hF80)] = 8'hA5;
        load_w(8'hFF);
        run(1'b0, 1'b0, 8'h7F, 4'h9, 0);
        load_w(8'hFF);
        run(1'b1, 1'b0, 8'h80, 4'h9, 0);

        // Other status bits survive an instruction.
        load_st(5'b01011);
        fmem[int'(12'h011)] = 8'h33;
        run(1'b0, 1'b0, 8'h11, 4'h0, 0);
        load_st(5'b11111);
        run(1'b0, 1'b1, 8'hEE, 4'h7, 0);

        // Wrong opcode is not accepted.
        @(negedge clk);
        instr = 16'h1C55; issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
        check("R1 bad opcode busy", busy, 1'b0);
        @(negedge clk);
        check("R1 bad opcode busy later", busy, 1'b0);
        check("R1 bad opcode w", w_out, w_m);

        // Second issue during an instruction.
        fmem[int'(12'h000)] = 8'h00;
        fmem[int'(12'h123)] = 8'h6C;
        load_w(8'hFE);
        run(1'b1, 1'b1, 8'h23, 4'h1, 1);
        @(negedge clk);
        check("R10 no second start", busy, 1'b0);

        // Mixed patterns.
        for (int i = 0; i < 40; i++) begin
            logic [7:0] f;
            logic [3:0] b;
            logic [11:0] ea;
            f = 8'($urandom);
            b = 4'($urandom);
            ea = {b, f};
            fmem[int'(ea)] = 8'($urandom);
            fmem[int'({{4{f[7]}}, f})] = 8'($urandom);
            if (i % 5 == 0) load_w(8'($urandom));
            run(1'($urandom), 1'($urandom), f, b, 0);
        end

        repeat (3) @(negedge clk);
        check("R2 scoreboard drained", sb_q.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule